// File: doc/BRIEF.md
# Instruction TLB Replacement Controller

This block holds the replacement state for a small fully associative instruction TLB and for the larger unified TLB next to it. For the instruction TLB it keeps a pairwise age matrix, one bit per pair of entries. Every hit marks the entry as most recently used. A refill strobe writes into the oldest entry and marks that entry as most recent in the same cycle. The current victim index is always shown on an output, together with a flag that is raised when the age bits name no oldest entry.

For the unified TLB it keeps a replacement counter. The counter steps on every unified-TLB access. It wraps to zero once it passes a bound that software sets, or once it passes the last entry when the bound is zero. A single 32-bit register write port loads the age bits, the bound and the counter at fixed bit positions, so the block fits inside a wider MMU control word. The TLB storage is outside this block.

Top module: `tlb_repl_ctrl`

## Requirements
- R1: After reset (rst_ni low) the age bits, counter and bound are all zero, the victim index is 3 and the illegal flag is low.
- R2: Age bit 5 relates entries (0,1), bit 4 (0,2), bit 3 (0,3), bit 2 (1,2), bit 1 (1,3) and bit 0 (2,3). A 1 means the lower-numbered entry of the pair is older. victim_o names the entry that is older than all others.
- R3: When no entry is older than all others, illegal_o is high and victim_o reads 0.
- R4: A hit (hit_i with hit_idx_i = k) clears every age bit whose pair has k as its lower entry and sets every bit whose pair has k as its higher entry, leaving the other bits unchanged. With no hit, fill or write the age bits hold.
- R5: A fill (fill_i) applies the R4 update to the victim shown in that cycle, and it takes precedence over a hit in the same cycle.
- R6: A fill while illegal_o is high leaves the age bits unchanged.
- R7: Each utlb_acc_i raises the counter by one. When the bound is nonzero and the counter would pass it, the counter becomes 0 instead.
- R8: With a zero bound the counter wraps from 63 to 0.
- R9: Without utlb_acc_i or a write, the counter holds.
- R10: reg_we_i loads the age bits from reg_wdata_i[31:26], the bound from [23:18] and the counter from [15:10]. It overrides any hit, fill or access in the same cycle.
- R11: An access while the counter is already above a nonzero bound sets the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | Instruction TLB hit strobe |
| hit_idx_i | input | 2 | Entry that hit |
| fill_i | input | 1 | Refill strobe into the victim entry |
| utlb_acc_i | input | 1 | Unified TLB access strobe |
| reg_we_i | input | 1 | Control field write |
| reg_wdata_i | input | 32 | Control word carrying the age, bound and counter fields |
| lru_o | output | 6 | Age bits |
| victim_o | output | 2 | Entry to replace on the next refill |
| illegal_o | output | 1 | Age bits name no oldest entry |
| urc_o | output | 6 | Unified TLB replacement counter |
| urb_o | output | 6 | Counter bound |

## Verification
The bench builds the block with its defaults: four entries, a 6-bit counter and 64 unified entries. With these values the natural wrap at 63 is reached within 64 accesses, and all 64 age-bit patterns are reachable through the write port. This includes the cyclic patterns that raise the illegal flag. Random writes therefore mix legal and illegal states, and the bench also drives small bounds and a counter written above its bound.

// File: rtl/tlb_repl_pkg.sv
package tlb_repl_pkg;
  // Bit position of pair (i,j), i<j, in an n-entry age vector, first pair at MSB.
  function automatic int pair_pos(int n, int i, int j);
    int ord;
    ord = 0;
    for (int a = 0; a < i; a++) ord += n - 1 - a;
    ord += j - i - 1;
    return n * (n - 1) / 2 - 1 - ord;
  endfunction
endpackage

// File: rtl/tlb_lru_decode.sv
module tlb_lru_decode #(
  parameter int N  = 4,
  parameter int PW = N * (N - 1) / 2,
  parameter int IW = $clog2(N)
) (
  input  logic [PW-1:0] lru_i,
  output logic [IW-1:0] victim_o,
  output logic          illegal_o
);
  import tlb_repl_pkg::*;

  logic [N-1:0][N-1:0] older;
  logic [N-1:0]        cand;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (j > i) begin : g_hi
        assign older[i][j] = lru_i[pair_pos(N, i, j)];
      end else if (j < i) begin : g_lo
        assign older[i][j] = ~lru_i[pair_pos(N, j, i)];
      end else begin : g_self
        assign older[i][j] = 1'b1;
      end
    end
    assign cand[i] = &older[i];
  end

  always_comb begin
    victim_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (cand[i]) victim_o = IW'(i);
  end

  assign illegal_o = ~|cand;

  always_comb begin
    if (illegal_o) assert (victim_o == '0) else $error("AST_ILLEGAL_ZERO"); // R3
  end
endmodule

// File: rtl/tlb_lru_state.sv
module tlb_lru_state #(
  parameter int N  = 4,
  parameter int PW = N * (N - 1) / 2,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_en_i,
  input  logic [IW-1:0] upd_idx_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_lru_i,
  output logic [PW-1:0] lru_o
);
  import tlb_repl_pkg::*;

  logic [PW-1:0] lru_q, set_m, clr_m;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        if (IW'(i) == upd_idx_i) clr_m[pair_pos(N, i, j)] = 1'b1;
        if (IW'(j) == upd_idx_i) set_m[pair_pos(N, i, j)] = 1'b1;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lru_q <= '0;
    else if (wr_en_i)  lru_q <= wr_lru_i;
    else if (upd_en_i) lru_q <= (lru_q & ~clr_m) | set_m;
  end

  assign lru_o = lru_q;

  AST_LRU_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !upd_en_i |=> $stable(lru_q)); // R4
  AST_LRU_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> lru_q == $past(wr_lru_i)); // R10
endmodule

// File: rtl/tlb_urc_counter.sv
module tlb_urc_counter #(
  parameter int CW      = 6,
  parameter int ENTRIES = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_cnt_i,
  input  logic [CW-1:0] wr_bnd_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] bnd_o
);
  localparam logic [CW:0] LAST = (CW + 1)'(ENTRIES - 1);

  logic [CW-1:0] cnt_q, bnd_q;
  logic [CW:0]   inc;
  logic          wrap;

  assign inc  = {1'b0, cnt_q} + 1'b1;
  assign wrap = ((bnd_q != '0) && (inc > {1'b0, bnd_q})) || (inc > LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bnd_q <= '0;
    end else if (wr_en_i) begin
      cnt_q <= wr_cnt_i;
      bnd_q <= wr_bnd_i;
    end else if (acc_i) begin
      cnt_q <= wrap ? '0 : inc[CW-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign bnd_o = bnd_q;

  AST_URC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !acc_i |=> $stable(cnt_q)); // R9
  AST_URC_BOUND_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !wr_en_i && bnd_q != '0 && cnt_q >= bnd_q |=> cnt_q == '0); // R7
  AST_URC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !wr_en_i && bnd_q != '0 && cnt_q < bnd_q |=> cnt_q == $past(cnt_q) + 1'b1); // R7
  AST_URC_TOP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !wr_en_i && bnd_q == '0 && {1'b0, cnt_q} == LAST |=> cnt_q == '0); // R8
endmodule

// File: rtl/tlb_repl_ctrl.sv
module tlb_repl_ctrl #(
  parameter int N            = 4,
  parameter int CNT_W        = 6,
  parameter int UTLB_ENTRIES = 64,
  parameter int DW           = 32,
  parameter int LRU_LSB      = 26,
  parameter int BND_LSB      = 18,
  parameter int CNT_LSB      = 10
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             hit_i,
  input  logic [$clog2(N)-1:0]             hit_idx_i,
  input  logic                             fill_i,
  input  logic                             utlb_acc_i,
  input  logic                             reg_we_i,
  input  logic [DW-1:0]                    reg_wdata_i,
  output logic [N*(N-1)/2-1:0]             lru_o,
  output logic [$clog2(N)-1:0]             victim_o,
  output logic                             illegal_o,
  output logic [CNT_W-1:0]                 urc_o,
  output logic [CNT_W-1:0]                 urb_o
);
  localparam int PW = N * (N - 1) / 2;
  localparam int IW = $clog2(N);

  logic          upd_en;
  logic [IW-1:0] upd_idx;

  // Fill targets the victim and wins over a hit; no update from an illegal state.
  assign upd_en  = fill_i ? ~illegal_o : hit_i;
  assign upd_idx = fill_i ? victim_o : hit_idx_i;

  tlb_lru_state #(.N(N), .PW(PW), .IW(IW)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_en_i  (upd_en),
    .upd_idx_i (upd_idx),
    .wr_en_i   (reg_we_i),
    .wr_lru_i  (reg_wdata_i[LRU_LSB +: PW]),
    .lru_o     (lru_o)
  );

  tlb_lru_decode #(.N(N), .PW(PW), .IW(IW)) u_dec (
    .lru_i     (lru_o),
    .victim_o  (victim_o),
    .illegal_o (illegal_o)
  );

  tlb_urc_counter #(.CW(CNT_W), .ENTRIES(UTLB_ENTRIES)) u_urc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (utlb_acc_i),
    .wr_en_i  (reg_we_i),
    .wr_cnt_i (reg_wdata_i[CNT_LSB +: CNT_W]),
    .wr_bnd_i (reg_wdata_i[BND_LSB +: CNT_W]),
    .cnt_o    (urc_o),
    .bnd_o    (urb_o)
  );

  AST_HIT_MRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && !fill_i && !reg_we_i |=> illegal_o || victim_o != $past(hit_idx_i)); // R4
  AST_FILL_MRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !illegal_o && !reg_we_i |=> illegal_o || victim_o != $past(victim_o)); // R5
  AST_FILL_ILLEGAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && illegal_o && !reg_we_i |=> $stable(lru_o)); // R6
endmodule

// File: tb/tb_tlb_repl_ctrl.sv
module tb_tlb_repl_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hit_i = 1'b0;
  logic [1:0]  hit_idx_i = '0;
  logic        fill_i = 1'b0;
  logic        utlb_acc_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [5:0]  lru_o;
  logic [1:0]  victim_o;
  logic        illegal_o;
  logic [5:0]  urc_o, urb_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0] m_lru = '0, m_urc = '0, m_urb = '0;
  string lru_tag = "R1", urc_tag = "R1";

  always #5 clk = ~clk;

  tlb_repl_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .hit_i(hit_i), .hit_idx_i(hit_idx_i),
    .fill_i(fill_i), .utlb_acc_i(utlb_acc_i), .reg_we_i(reg_we_i),
    .reg_wdata_i(reg_wdata_i), .lru_o(lru_o), .victim_o(victim_o),
    .illegal_o(illegal_o), .urc_o(urc_o), .urb_o(urb_o)
  );

  function automatic logic [2:0] ref_victim(logic [5:0] l); // {illegal, idx}
    if ((l & 6'b111000) == 6'b111000) return 3'b000;
    if ((l & 6'b100110) == 6'b000110) return 3'b001;
    if ((l & 6'b010101) == 6'b000001) return 3'b010;
    if ((l & 6'b001011) == 6'b000000) return 3'b011;
    return 3'b100;
  endfunction

  function automatic logic [5:0] ref_use(logic [5:0] l, logic [1:0] k);
    case (k)
      2'd0: return l & 6'b000111;
      2'd1: return (l & 6'b111001) | 6'b100000;
      2'd2: return (l & 6'b111110) | 6'b010100;
      default: return l | 6'b001011;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic [2:0] v;
    v = ref_victim(m_lru);
    chk(lru_tag, "lru", lru_o, m_lru);
    chk("R2", "victim", victim_o, v[1:0]);
    chk("R3", "illegal", illegal_o, v[2]);
    chk(urc_tag, "urc", urc_o, m_urc);
    chk(urc_tag, "urb", urb_o, m_urb);
  endtask

  // Drive one cycle at negedge, predict, then check at the following negedge.
  task automatic step(logic h, logic [1:0] hi, logic f, logic a, logic w, logic [31:0] wd);
    logic [2:0] v;
    logic [6:0] inc;
    hit_i = h; hit_idx_i = hi; fill_i = f; utlb_acc_i = a; reg_we_i = w; reg_wdata_i = wd;
    v = ref_victim(m_lru);
    if (w) begin
      m_lru = wd[31:26]; m_urb = wd[23:18]; m_urc = wd[15:10];
      lru_tag = "R10"; urc_tag = "R10";
    end else begin
      if (f) begin
        lru_tag = v[2] ? "R6" : "R5";
        if (!v[2]) m_lru = ref_use(m_lru, v[1:0]);
      end else if (h) begin
        lru_tag = "R4"; m_lru = ref_use(m_lru, hi);
      end else lru_tag = "R4";
      if (a) begin
        inc = {1'b0, m_urc} + 7'd1;
        if (m_urb != 0 && m_urc > m_urb) begin urc_tag = "R11"; m_urc = '0; end
        else if (m_urb != 0 && inc > {1'b0, m_urb}) begin urc_tag = "R7"; m_urc = '0; end
        else if (inc > 7'd63) begin urc_tag = "R8"; m_urc = '0; end
        else begin urc_tag = "R7"; m_urc = inc[5:0]; end
      end else urc_tag = "R9";
    end
    @(negedge clk);
    check_all();
  endtask

  function automatic logic [31:0] wword(logic [5:0] l, logic [5:0] b, logic [5:0] c);
    return {l, 2'b00, b, 2'b00, c, 10'd0};
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all(); // R1 reset state
    chk("R1", "victim after reset", victim_o, 3);
    rst_ni = 1'b1;
    @(negedge clk);
    // R4 directed hits, then R5 fills on the victim
    step(1, 2'd3, 0, 0, 0, '0);
    step(1, 2'd0, 0, 0, 0, '0);
    step(1, 2'd2, 1, 0, 0, '0); // fill wins over hit
    step(0, 2'd0, 1, 0, 0, '0);
    // R3/R6 illegal cyclic state, fill ignored
    step(0, 2'd0, 0, 0, 1, wword(6'b101111, 6'd0, 6'd0));
    chk("R3", "illegal cyclic", illegal_o, 1);
    step(0, 2'd0, 1, 0, 0, '0);
    chk("R6", "lru kept", lru_o, 6'b101111);
    // R7 bound 3
    step(0, 2'd0, 0, 0, 1, wword(6'b111000, 6'd3, 6'd0));
    for (int i = 0; i < 6; i++) step(0, 2'd0, 0, 1, 0, '0);
    chk("R7", "count after 6 at bound 3", urc_o, 2);
    // R11 counter above bound
    step(0, 2'd0, 0, 0, 1, wword(6'b000000, 6'd3, 6'd10));
    step(0, 2'd0, 0, 1, 0, '0);
    chk("R11", "reset above bound", urc_o, 0);
    // R8 zero bound wrap
    step(0, 2'd0, 0, 0, 1, wword(6'b000000, 6'd0, 6'd62));
    step(0, 2'd0, 0, 1, 0, '0);
    step(0, 2'd0, 0, 1, 0, '0);
    chk("R8", "wrap from 63", urc_o, 0);
    // R9 hold
    step(0, 2'd0, 0, 0, 0, '0);
    // R10 write overrides everything
    step(1, 2'd1, 1, 1, 1, wword(6'b010101, 6'd5, 6'd4));
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [5:0] b;
      r = $urandom_range(0, 99);
      b = ($urandom_range(0, 3) == 0) ? 6'd0 : 6'($urandom_range(1, 12));
      step(r < 40, 2'($urandom), r >= 30 && r < 60, ($urandom_range(0, 2) != 0),
           r >= 95, wword(6'($urandom), b, 6'($urandom_range(0, 20))));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule